// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block connects a clocked host to an 8K x 8 asynchronous static RAM. The host sends one word at a time over a request/ready handshake: a 13-bit address, a write flag and, for writes, one data byte. The block turns each request into the strobe sequence the memory needs. For a read it gives the select, address and output-enable phase and then returns the byte with a one-cycle valid pulse. For a write it gives the select, address and write-enable pulse and drives the data bus only when that is safe.

The memory is selected only when both select pins are active: one is active low and the other active high. Writes are controlled by write enable. Each phase length is a clock count set by a parameter. The defaults suit the 70 ns speed grade at a 100 MHz clock: read 7, write setup 1, write pulse 5, write hold 1, bus turnaround 3. For the 100 ns grade at the same clock, use 10, 2, 6, 2 and 4.

The data bus appears as three separate signals: a driven value, a driver enable and a sampled input. The tri-state pad is built outside the block.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is 1, the memory is deselected: `mem_sel_n`=1 and `mem_sel`=0. In that state `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0. An asynchronous reset that arrives in the middle of an access returns these values at once.
- R2: Once a read is accepted (`req_valid`=1, `req_ready`=1, `req_write`=0 at a clock edge), the next RD_CYC cycles show `mem_sel_n`=0, `mem_sel`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_addr` equal to the requested address. `req_ready` is 0 during those cycles.
- R3: The byte on `mem_dq_in` during the last read cycle is registered on the edge that ends that cycle. It appears on `rsp_rdata` with `rsp_valid`=1 for exactly one cycle, the one right after the read phase.
- R4: During a write, `mem_we_n` is 0 for exactly WPULSE_CYC consecutive cycles. Through all of them the memory is selected, `mem_oe_n`=1, `mem_dq_oe`=1, `mem_dq_out` holds the request byte and `mem_addr` holds the request address.
- R5: `mem_dq_oe` goes from 0 to 1 only after `mem_oe_n` has been 1 for at least TURN_CYC whole cycles in a row. Reset counts as zero such cycles.
- R6: Before `mem_we_n` falls, the memory has been selected with `mem_we_n`=1 for at least WSETUP_CYC cycles. That wait lasts no longer than the larger of WSETUP_CYC and TURN_CYC.
- R7: `mem_dq_oe` stays 1 in the first cycle after `mem_we_n` rises and is 0 in the cycle after that.
- R8: After the write pulse, the memory stays selected with `mem_we_n`=1 for WHOLD_CYC cycles. Then the block is idle and `req_ready`=1.
- R9: A request is taken only in a cycle where `req_ready`=1. `req_valid` asserted while an access is under way starts no access and produces no strobe.
- R10: `mem_oe_n` and `mem_we_n` are never both 0. `mem_sel_n` is always the inverse of `mem_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle; accepts a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: read byte valid |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 13 | Memory address pins |
| mem_sel_n | output | 1 | Active-low select |
| mem_sel | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Value for the data pad driver |
| mem_dq_oe | output | 1 | Data pad driver enable |
| mem_dq_in | input | 8 | Sampled data pad value |

## Verification
The main function is tried with four kinds of access sequence. A write straight after a read shows whether the turnaround wait is counted from the moment output enable rose. A write after a long idle spell shows that the wait shrinks to the setup count. A write followed at once by a read of the same address checks both the byte returned and that the driver was released before output enable fell. Long random mixes, including the first and last address and the all-zero and all-one bytes, show that addresses and data are not mixed up between requests. A request raised while the block is busy, and a reset in the middle of a write pulse, check that a stray input changes nothing and that a reset clears all strobes at once.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE   = 3'd0,
    SEQ_READ   = 3'd1,
    SEQ_WSETUP = 3'd2,
    SEQ_WPULSE = 3'd3,
    SEQ_WHOLD  = 3'd4
  } seq_state_e;

  function automatic int unsigned max_of2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned MAX_CNT = 7,
  localparam int unsigned CW = (MAX_CNT < 1) ? 1 : $clog2(MAX_CNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart)
      cnt_d = '0;
    else if (cnt_q == CW'(MAX_CNT))
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/sram_turn_counter.sv
module sram_turn_counter #(
  parameter int unsigned TURN_CYC = 3,
  localparam int unsigned TW = $clog2(TURN_CYC + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n_level,
  output logic bus_quiet
);

  logic [TW-1:0] hi_q, hi_d;

  always_comb begin
    if (!oe_n_level)
      hi_d = '0;
    else if (hi_q >= TW'(TURN_CYC))
      hi_d = hi_q;
    else
      hi_d = hi_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end

  // Counting this cycle too, output enable has then been high for TURN_CYC cycles.
  assign bus_quiet = oe_n_level && (({1'b0, hi_q} + (TW+1)'(1)) >= (TW+1)'(TURN_CYC));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC     = 7,
  parameter int unsigned WSETUP_CYC = 1,
  parameter int unsigned WPULSE_CYC = 5,
  parameter int unsigned WHOLD_CYC  = 1,
  parameter int unsigned PH_W       = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            bus_quiet,
  input  logic [PH_W-1:0] phase_cnt,
  output seq_state_e      state,
  output logic            restart,
  output logic            accept
);

  seq_state_e state_q, state_d;
  logic       setup_done;

  assign accept     = (state_q == SEQ_IDLE) && req_valid;
  assign setup_done = (({1'b0, phase_cnt} + (PH_W+1)'(1)) >= (PH_W+1)'(WSETUP_CYC));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (req_valid) state_d = req_write ? SEQ_WSETUP : SEQ_READ;
      SEQ_READ:   if (phase_cnt == PH_W'(RD_CYC - 1)) state_d = SEQ_IDLE;
      SEQ_WSETUP: if (setup_done && bus_quiet) state_d = SEQ_WPULSE;
      SEQ_WPULSE: if (phase_cnt == PH_W'(WPULSE_CYC - 1)) state_d = SEQ_WHOLD;
      SEQ_WHOLD:  if (phase_cnt == PH_W'(WHOLD_CYC - 1)) state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign restart = (state_d != state_q);
  assign state   = state_q;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RD_CYC     = 7,
  parameter int unsigned WSETUP_CYC = 1,
  parameter int unsigned WPULSE_CYC = 5,
  parameter int unsigned WHOLD_CYC  = 1,
  parameter int unsigned TURN_CYC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned CNT_MAX = max_of2(max_of2(RD_CYC, WSETUP_CYC),
                                            max_of2(WPULSE_CYC, WHOLD_CYC));
  localparam int unsigned PH_W = (CNT_MAX < 1) ? 1 : $clog2(CNT_MAX + 1);

  seq_state_e        state;
  logic              restart, accept, bus_quiet;
  logic [PH_W-1:0]   phase_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;
  logic              last_read, selected, oe_n_int;

  sram_seq_fsm #(
    .RD_CYC(RD_CYC), .WSETUP_CYC(WSETUP_CYC), .WPULSE_CYC(WPULSE_CYC),
    .WHOLD_CYC(WHOLD_CYC), .PH_W(PH_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .bus_quiet(bus_quiet), .phase_cnt(phase_cnt), .state(state),
    .restart(restart), .accept(accept)
  );

  sram_phase_timer #(.MAX_CNT(CNT_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .count(phase_cnt)
  );

  sram_turn_counter #(.TURN_CYC(TURN_CYC)) u_turn (
    .clk(clk), .rst_n(rst_n), .oe_n_level(oe_n_int), .bus_quiet(bus_quiet)
  );

  // Request capture, clock-enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign last_read = (state == SEQ_READ) && (phase_cnt == PH_W'(RD_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (last_read) rdata_q <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= last_read;
  end

  // Strobe decode from the registered phase
  assign selected   = (state != SEQ_IDLE);
  assign oe_n_int   = (state != SEQ_READ);
  assign mem_sel_n  = !selected;
  assign mem_sel    = selected;
  assign mem_oe_n   = oe_n_int;
  assign mem_we_n   = (state != SEQ_WPULSE);
  assign mem_dq_oe  = (state == SEQ_WPULSE) ||
                      ((state == SEQ_WHOLD) && (phase_cnt == '0));
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign req_ready  = (state == SEQ_IDLE);
  assign rsp_valid  = rvalid_q;
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int unsigned WSETUP_CYC = 1,
  parameter int unsigned WPULSE_CYC = 5,
  parameter int unsigned TURN_CYC   = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic mem_sel_n,
  input logic mem_sel,
  input logic mem_oe_n,
  input logic mem_we_n,
  input logic mem_dq_oe
);

  logic [31:0] oe_hi_cnt, setup_cnt, pulse_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_cnt <= '0;
      setup_cnt <= '0;
      pulse_cnt <= '0;
    end else begin
      oe_hi_cnt <= !mem_oe_n ? '0 : ((oe_hi_cnt == 32'hFFFF_FFFF) ? oe_hi_cnt : oe_hi_cnt + 1);
      setup_cnt <= (mem_sel && mem_we_n) ? ((setup_cnt == 32'hFFFF_FFFF) ? setup_cnt : setup_cnt + 1) : '0;
      pulse_cnt <= !mem_we_n ? pulse_cnt + 1 : '0;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (pulse_cnt == 32'(WPULSE_CYC)));

  // R4
  pulse_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && mem_sel && mem_oe_n));

  // R5
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= 32'(TURN_CYC)));

  // R6
  setup_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (setup_cnt >= 32'(WSETUP_CYC)));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe ##1 !mem_dq_oe);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n) && (mem_sel_n == !mem_sel));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .WSETUP_CYC(WSETUP_CYC), .WPULSE_CYC(WPULSE_CYC), .TURN_CYC(TURN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_strobe_ctrl.sv
module sim_sram_strobe_ctrl;

  localparam int RD  = 7;
  localparam int WS  = 1;
  localparam int WP  = 5;
  localparam int WH  = 1;
  localparam int TRN = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [12:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hA5;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  logic [7:0] model_mem [int];
  logic [7:0] ref_mem   [int];

  int  mon_hi = 0;
  bit  prev_dq_oe = 0;
  int  r5_viol = 0, r10_viol = 0;

  always #10 clk = ~clk;

  sram_strobe_ctrl #(
    .RD_CYC(RD), .WSETUP_CYC(WS), .WPULSE_CYC(WP), .WHOLD_CYC(WH), .TURN_CYC(TRN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  function automatic logic [7:0] init_byte(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  function automatic logic [7:0] model_get(input logic [12:0] a);
    if (model_mem.exists(int'(a))) return model_mem[int'(a)];
    return init_byte(a);
  endfunction

  function automatic logic [7:0] ref_get(input logic [12:0] a);
    if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
    return init_byte(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model and continuous monitors (R5, R10), sampled mid-cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_hi     = 0;
      prev_dq_oe = 0;
    end else begin
      if (mem_dq_oe && !prev_dq_oe && mon_hi < TRN) r5_viol++;
      if ((!mem_oe_n && !mem_we_n) || (mem_sel_n == mem_sel)) r10_viol++;
      prev_dq_oe = mem_dq_oe;
      mon_hi = mem_oe_n ? mon_hi + 1 : 0;
      if (!mem_sel_n && mem_sel && !mem_we_n && mem_dq_oe)
        model_mem[int'(mem_addr)] = mem_dq_out;
    end
    mem_dq_in <= (!mem_sel_n && mem_sel && !mem_oe_n) ? model_get(mem_addr) : 8'hA5;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_wdata = ~d;
  endtask

  task automatic do_read(input logic [12:0] a);
    bit ok = 1;
    logic [7:0] exp = ref_get(a);
    issue(1'b0, a, 8'h00);
    for (int i = 0; i < RD; i++) begin
      if (mem_sel_n || !mem_sel || mem_oe_n || !mem_we_n || mem_addr != a || req_ready) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R2 read strobes", {19'b0, mem_addr}, {19'b0, a});
    chk(rsp_valid && rsp_rdata == exp, "R3 read data", {23'b0, rsp_valid, rsp_rdata}, {23'b0, 1'b1, exp});
    @(negedge clk);
    chk(!rsp_valid, "R3 single pulse", {31'b0, rsp_valid}, 0);
  endtask

  task automatic do_write(input logic [12:0] a, input logic [7:0] d);
    int  wait_cnt = 0;
    bit  ok = 1;
    int  upper = (WS > TRN) ? WS : TRN;
    issue(1'b1, a, d);
    ref_mem[int'(a)] = d;
    while (mem_we_n && wait_cnt < 50) begin
      if (mem_sel_n || !mem_sel || !mem_oe_n || mem_dq_oe || mem_addr != a) ok = 0;
      wait_cnt++;
      @(negedge clk);
    end
    chk(ok && wait_cnt >= WS && wait_cnt <= upper, "R6 setup wait", wait_cnt, WS);
    ok = 1;
    for (int i = 0; i < WP; i++) begin
      if (mem_we_n || !mem_dq_oe || mem_dq_out != d || mem_addr != a || !mem_oe_n || mem_sel_n) ok = 0;
      @(negedge clk);
    end
    chk(ok, "R4 write pulse", {24'b0, mem_dq_out}, {24'b0, d});
    ok = 1;
    for (int i = 0; i < WH; i++) begin
      if (!mem_we_n || mem_sel_n || !mem_sel) ok = 0;
      if (i == 0) chk(mem_dq_oe, "R7 driver held one cycle", {31'b0, mem_dq_oe}, 1);
      else if (mem_dq_oe) ok = 0;
      @(negedge clk);
    end
    chk(!mem_dq_oe, "R7 driver released", {31'b0, mem_dq_oe}, 0);
    chk(ok && req_ready && mem_sel_n, "R8 hold then idle", {31'b0, req_ready}, 1);
  endtask

  task automatic check_idle(input string req);
    chk(req_ready && mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe, req,
        {26'b0, req_ready, mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe}, 32'b110110);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset release");

    // Directed corners
    do_write(13'h0000, 8'h00);
    do_write(13'h1FFF, 8'hFF);
    do_read(13'h1FFF);
    do_write(13'h0123, 8'h5A);    // write straight after a read: full turnaround
    do_read(13'h0123);
    do_read(13'h0000);
    do_read(13'h0777);            // never written
    repeat (6) @(negedge clk);
    do_write(13'h0456, 8'hC3);    // after long idle: setup count only

    // R9: request raised while busy must be ignored
    issue(1'b0, 13'h0010, 8'h00);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h0011; req_wdata = 8'h99;
    @(negedge clk);
    req_valid = 1'b0;
    begin
      bit ok = 1;
      for (int i = 0; i < RD + 4; i++) begin
        if (!mem_we_n || mem_dq_oe) ok = 0;
        @(negedge clk);
      end
      chk(ok && req_ready, "R9 busy request ignored", {31'b0, mem_we_n}, 1);
    end
    do_read(13'h0011);

    // R1: reset in the middle of a write pulse
    issue(1'b1, 13'h0ABC, 8'h3C);
    while (mem_we_n) @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R1 async reset mid-write");
    @(negedge clk);
    rst_n = 1'b1;
    ref_mem[int'(13'h0ABC)] = model_get(13'h0ABC);
    @(negedge clk);
    check_idle("R1 idle after mid-write reset");

    // Random mix
    for (int n = 0; n < 60; n++) begin
      logic [12:0] a = 13'($urandom_range(0, 8191));
      logic [7:0]  d = 8'($urandom);
      if (n % 7 == 0) a = 13'h1FFF;
      if ($urandom_range(0, 1) == 1) do_write(a, d);
      else                           do_read(a);
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 5)) @(negedge clk);
    end

    chk(r5_viol == 0, "R5 turnaround before drive", r5_viol, 0);
    chk(r10_viol == 0, "R10 strobe exclusivity", r10_viol, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule